// File: doc/BRIEF.md
# Slave Sync Input Interface

This block aligns a video raster to timing supplied from outside. It watches two reference pins. The first one, `fref_i`, carries an edge of selectable polarity. Depending on a two-bit mode it is read as a vertical sync, as an odd/even field marker, or as a marker for the first field of a multi-field sequence. The second pin, `href_i`, supplies horizontal phase through its rising edge. It can instead be set to blank the video path for as long as it is high.

The block does not own the raster counters. For each active reference it issues single-cycle load strobes, and it captures the programmed horizontal and vertical trigger offsets, which the counters load on those strobes. If a reference is missing, no strobe is issued and the counters run on freely. A reference at the wrong phase is not filtered out: it re-aligns the counters. When `slave_en` is low, both pins are ignored.

Both pins are passed through a two-flop synchronizer, followed by one edge-history flop. A registered strobe therefore appears on the third clock edge after the pin changes.

Top module: `slave_sync_in`

## Requirements
- R1: The active edge of `fref_i` is rising when `fref_fall` is 0 and falling when `fref_fall` is 1; the opposite edge produces no strobe.
- R2: With `fref_mode` = 0 (vertical sync), an active edge raises only `vload_o`, never `fld_odd_o`, `seq_first_o` or `sc_rst_o`, and never `hload_o` from this pin.
- R3: With `fref_mode` = 1 (odd/even), an active edge raises `vload_o` and `fld_odd_o` together, and also raises `hload_o` when `fref_hset` is 1.
- R4: With `fref_mode` = 2 (field sequence), an active edge raises `vload_o`, `fld_odd_o` and `seq_first_o`, raises `hload_o` when `fref_hset` is 1, and raises `sc_rst_o` only when `sc_rst_en` is 1.
- R5: While `href_blank` is 0, each rising edge of `href_i` raises `hload_o`.
- R6: While `href_blank` is 1, `blank_o` follows the synchronized level of `href_i`, and `href_i` edges raise no `hload_o`.
- R7: While `slave_en` is 0, every strobe and `blank_o` stay low, whatever the pins do.
- R8: On each `hload_o`, `hval_o` takes the value of `h_trig`. On each `vload_o`, `vval_o` takes `v_trig`, a count of half lines after the first serration pulse, from 0 to 31. Both values hold between strobes.
- R9: A strobe lasts exactly one cycle and is visible after the third rising clock edge that follows the pin change.
- R10: Every active edge produces its strobe, however closely it follows the previous one. With no edges, no strobes occur.
- R11: With `fref_mode` = 3, `fref_i` produces no strobe.
- R12: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | 1 = follow the references, 0 = ignore them |
| fref_i | input | 1 | Field/vertical reference pin |
| href_i | input | 1 | Horizontal reference / blanking pin |
| fref_fall | input | 1 | 1 selects the falling edge of `fref_i` |
| fref_mode | input | 2 | 0 vertical sync, 1 odd/even, 2 field sequence, 3 unused |
| fref_hset | input | 1 | Odd/even and sequence edges also load horizontal phase |
| sc_rst_en | input | 1 | Sequence edge also resets subcarrier phase |
| href_blank | input | 1 | `href_i` acts as a blanking input |
| h_trig | input | H_W | Horizontal trigger pixel |
| v_trig | input | V_W | Vertical trigger in half lines |
| hload_o | output | 1 | Horizontal phase load strobe |
| vload_o | output | 1 | Vertical phase load strobe |
| fld_odd_o | output | 1 | Force the field flag to odd |
| seq_first_o | output | 1 | Set the sequence phase to its first field |
| sc_rst_o | output | 1 | Reset the subcarrier phase |
| blank_o | output | 1 | Blank the video path |
| hval_o | output | H_W | Horizontal load value |
| vval_o | output | V_W | Vertical load value |

## Verification
A wrong synchronizer or edge-history state shows up as a strobe that is one cycle off, a strobe that is missing, or a strobe with no edge behind it. A wrong mode decode shows up as the wrong set of strobes for a given edge. Any of these appears within three cycles of the pin change that should have caused it. A captured value that is stale or loaded without a strobe shows on `hval_o` or `vval_o` in the cycle the strobe appears, and it stays wrong until the next strobe.

// File: rtl/slave_sync_in.sv
module slave_sync_in #(
  parameter int H_W = 11,
  parameter int V_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slave_en,
  input  logic           fref_i,
  input  logic           href_i,
  input  logic           fref_fall,
  input  logic [1:0]     fref_mode,
  input  logic           fref_hset,
  input  logic           sc_rst_en,
  input  logic           href_blank,
  input  logic [H_W-1:0] h_trig,
  input  logic [V_W-1:0] v_trig,
  output logic           hload_o,
  output logic           vload_o,
  output logic           fld_odd_o,
  output logic           seq_first_o,
  output logic           sc_rst_o,
  output logic           blank_o,
  output logic [H_W-1:0] hval_o,
  output logic [V_W-1:0] vval_o
);
  localparam logic [1:0] MODE_VS = 2'd0;
  localparam logic [1:0] MODE_OE = 2'd1;
  localparam logic [1:0] MODE_FS = 2'd2;

  logic [2:0] f_sh, h_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_sh <= '0;
      h_sh <= '0;
    end else begin
      f_sh <= {f_sh[1:0], fref_i};
      h_sh <= {h_sh[1:0], href_i};
    end

  wire f_edge  = fref_fall ? (f_sh[2] & ~f_sh[1]) : (~f_sh[2] & f_sh[1]);
  wire h_rise  = ~h_sh[2] & h_sh[1];
  wire fld_sel = (fref_mode == MODE_OE) || (fref_mode == MODE_FS);

  wire v_go   = slave_en & f_edge & (fld_sel || fref_mode == MODE_VS);
  wire fld_go = slave_en & f_edge & fld_sel;
  wire seq_go = slave_en & f_edge & (fref_mode == MODE_FS);
  wire h_go   = slave_en & ((fld_go & fref_hset) | (h_rise & ~href_blank));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hload_o     <= 1'b0;
      vload_o     <= 1'b0;
      fld_odd_o   <= 1'b0;
      seq_first_o <= 1'b0;
      sc_rst_o    <= 1'b0;
      blank_o     <= 1'b0;
      hval_o      <= '0;
      vval_o      <= '0;
    end else begin
      hload_o     <= h_go;
      vload_o     <= v_go;
      fld_odd_o   <= fld_go;
      seq_first_o <= seq_go;
      sc_rst_o    <= seq_go & sc_rst_en;
      blank_o     <= slave_en & href_blank & h_sh[1];
      if (h_go) hval_o <= h_trig;
      if (v_go) vval_o <= v_trig;
    end
endmodule

// File: rtl/slave_sync_in_chk.sv
module slave_sync_in_chk #(
  parameter int H_W = 11,
  parameter int V_W = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           slave_en,
  input logic           hload_o,
  input logic           vload_o,
  input logic           fld_odd_o,
  input logic           seq_first_o,
  input logic           sc_rst_o,
  input logic           blank_o,
  input logic [H_W-1:0] hval_o,
  input logic [V_W-1:0] vval_o
);
  // R3
  fld_implies_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_odd_o |-> vload_o);
  // R4
  seq_implies_fld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_first_o |-> fld_odd_o);
  // R4
  sc_implies_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rst_o |-> seq_first_o);
  // R7
  master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slave_en) |-> !(hload_o || vload_o || blank_o));
  // R9
  v_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vload_o |=> !vload_o);
  // R8
  vval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vval_o) |-> vload_o);
  // R8
  hval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hval_o) |-> hload_o);
endmodule

bind slave_sync_in slave_sync_in_chk #(.H_W(H_W), .V_W(V_W)) chk_i (.*);

// File: tb/slave_sync_in_tb.sv
module slave_sync_in_tb_top;
  localparam int H_W = 11;
  localparam int V_W = 5;

  logic clk = 0, rst_n = 0;
  logic slave_en = 0, fref_i = 0, href_i = 0, fref_fall = 0;
  logic [1:0] fref_mode = 0;
  logic fref_hset = 0, sc_rst_en = 0, href_blank = 0;
  logic [H_W-1:0] h_trig = 0;
  logic [V_W-1:0] v_trig = 0;
  logic hload_o, vload_o, fld_odd_o, seq_first_o, sc_rst_o, blank_o;
  logic [H_W-1:0] hval_o;
  logic [V_W-1:0] vval_o;

  int tests = 0, fails = 0;
  int fh[4], hh[4];
  int e_h, e_v, e_f, e_s, e_c, e_b, e_hv, e_vv;

  always #2 clk = ~clk;

  slave_sync_in #(.H_W(H_W), .V_W(V_W)) dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference: pin samples two and three edges back form the edge
  always @(posedge clk) begin
    for (int i = 3; i > 0; i--) begin fh[i] = fh[i-1]; hh[i] = hh[i-1]; end
    fh[0] = rst_n ? int'(fref_i) : 0;
    hh[0] = rst_n ? int'(href_i) : 0;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin fh[i] = 0; hh[i] = 0; end
      {e_h, e_v, e_f, e_s, e_c, e_b, e_hv, e_vv} = '{default:0};
    end else begin
      bit fe, hr, is_fld;
      fe = fref_fall ? (fh[3] == 1 && fh[2] == 0) : (fh[3] == 0 && fh[2] == 1);
      hr = hh[3] == 0 && hh[2] == 1;
      is_fld = fref_mode == 1 || fref_mode == 2;
      e_v = (slave_en && fe && fref_mode != 3) ? 1 : 0;
      e_f = (slave_en && fe && is_fld) ? 1 : 0;
      e_s = (slave_en && fe && fref_mode == 2) ? 1 : 0;
      e_c = (e_s == 1 && sc_rst_en) ? 1 : 0;
      e_h = (slave_en && ((e_f == 1 && fref_hset) || (hr && !href_blank))) ? 1 : 0;
      e_b = (slave_en && href_blank && hh[2] == 1) ? 1 : 0;
      if (e_h == 1) e_hv = int'(h_trig);
      if (e_v == 1) e_vv = int'(v_trig);
    end
    #1;
    if (!rst_n) begin
      chk("R12 reset hload", hload_o, 0);
      chk("R12 reset vload", vload_o, 0);
      chk("R12 reset blank", blank_o, 0);
      chk("R12 reset vval", vval_o, 0);
    end else begin
      chk("R1/R2/R9/R10 vload", vload_o, e_v);
      chk("R3 fld_odd", fld_odd_o, e_f);
      chk("R4 seq_first", seq_first_o, e_s);
      chk("R4 sc_rst", sc_rst_o, e_c);
      chk("R5 hload", hload_o, e_h);
      chk("R6 blank", blank_o, e_b);
      chk("R8 hval", hval_o, e_hv);
      chk("R8 vval", vval_o, e_vv);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fpulse(int hi, int lo);
    @(negedge clk) fref_i = ~fref_i;
    idle(hi);
    fref_i = ~fref_i;
    idle(lo);
  endtask

  task automatic hpulse(int hi, int lo);
    @(negedge clk) href_i = 1;
    idle(hi);
    href_i = 0;
    idle(lo);
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    slave_en = 1;
    idle(3);
    // R2 vertical sync mode, R1 rising edge, R8 values
    fref_mode = 0; v_trig = 5'd7; h_trig = 11'd1000;
    fpulse(3, 6);
    hpulse(2, 6);           // R5
    // R1 falling edge polarity
    fref_fall = 1; v_trig = 5'd31;
    fref_i = 1; idle(6);
    fpulse(4, 6);
    fref_i = 0; idle(6);
    fref_fall = 0;
    // R3 odd/even with and without horizontal set
    fref_mode = 1; fref_hset = 0; v_trig = 5'd0;
    fpulse(2, 6);
    fref_hset = 1; h_trig = 11'd1727;
    fpulse(2, 6);
    // R4 field sequence, subcarrier reset off then on
    fref_mode = 2; sc_rst_en = 0; v_trig = 5'd16;
    fpulse(2, 6);
    sc_rst_en = 1; h_trig = 11'd3;
    fpulse(2, 6);
    // R10 back-to-back edges, no filtering
    for (int i = 0; i < 4; i++) fpulse(1, 1);
    for (int i = 0; i < 4; i++) hpulse(1, 1);
    idle(8);
    // R11 unused mode
    fref_mode = 3;
    fpulse(2, 6);
    // R6 blank mode
    fref_mode = 0; href_blank = 1; h_trig = 11'd55;
    hpulse(5, 6);
    href_blank = 0;
    idle(4);
    // R7 master mode ignores everything
    slave_en = 0; fref_mode = 2; href_blank = 1;
    fpulse(2, 6);
    hpulse(3, 6);
    href_blank = 0;
    hpulse(3, 6);
    slave_en = 1;
    idle(6);
    // R10 no edges, no strobes
    idle(20);
    // R12 reset again mid-run
    @(negedge clk) rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule